// File: doc/BRIEF.md
# Boot Mode Entry Controller

This block decides, cycle by cycle, whether the processor fetches code from the external program memory on its primary chip select or from a small internal boot ROM. It samples a two-bit mode strap once reset has been released. It samples the strap again each time the boot ROM program restarts. It also samples it while normal code runs, but only when the program counter reaches a 16-byte aligned address. Software can override the strap with one bit in a control register and keep the processor running normally.

Any transition into bootstrap mode raises a single-cycle wipe request for the secure on-chip RAM. This holds whether the transition comes from the strap at reset, from a run-time resample, or from software clearing the override bit. A loader placed in memory therefore cannot read that RAM out.

Top module: `boot_entry_top`

## Requirements
- R1: While `rstN` is low, `bootActive`, `bootSrc`, `fetchInhibit` and `secureErase` are all 0, and the override bit is 0.
- R2: On the first rising clock edge with `rstN` high, the strap is sampled. Code 00 leaves normal fetch (`bootActive`=0, `bootSrc`=0). Code 01 selects the slave port, 10 the clocked serial port and 11 the asynchronous serial port. Any nonzero code sets `bootActive`=1 and makes `bootSrc` equal to the code.
- R3: `fetchInhibit` is 1 exactly when the block is in bootstrap mode, so the primary chip-select fetch is blocked while the boot ROM is in use.
- R4: `secureErase` is 1 for exactly one cycle, in the same cycle that `bootActive` first reads 1 after having been 0. It stays 0 while bootstrap mode simply continues.
- R5: With the override bit at 0 and bootstrap active, a `romRestart` pulse resamples the strap. A nonzero code updates `bootSrc` without raising `secureErase`. Code 00 returns to normal fetch.
- R6: Writing the control register (`ctrlWrEn`=1) with bit 7 of `ctrlWrData` at 1 sets the override. From the second clock edge after that write, `bootActive`=0. While the override is 1, the strap, `romRestart` and the program counter have no effect.
- R7: With the override bit at 0 and normal fetch in effect, the strap is sampled at every edge where `pc[3:0]` is 0000, and a nonzero code enters bootstrap. At any other PC value, no sampling takes place.
- R8: The override bit changes only on edges where `ctrlWrEn` is 1. Writing bit 7 as 0 clears it, and the next sample point then acts on the strap.
- R9: Between sample points, changes on `modePins` do not alter any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modePins | input | 2 | Boot strap code |
| pc | input | 16 | Current program counter |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control register write data; bit 7 is the override |
| romRestart | input | 1 | Execution jumped to the boot ROM start |
| bootActive | output | 1 | Bootstrap mode in effect |
| bootSrc | output | 2 | Selected boot source (strap code), 0 when not booting |
| fetchInhibit | output | 1 | Blocks the primary chip-select fetch |
| secureErase | output | 1 | One-cycle secure RAM wipe request |

## Verification
The assertions check the wipe pulse on every cycle. It may only coincide with a rising boot flag, it must accompany every rise, and it never lasts two cycles. The checker also confirms that every entry follows a nonzero strap, and that the boot flag is low two edges after an override write. Which sample point actually fires can only be seen in the bench's scenarios: the first edge after reset, restarts under each strap code, and the sweep over all sixteen low PC nibbles. The same holds for the inertness of the strap between sample points and under the override.

// File: rtl/boot_entry_pkg.sv
package boot_entry_pkg;

  localparam int MODE_W = 2;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic forceRun;   // override set: drop bootstrap, ignore strap
    logic evalPins;   // act on the current strap code this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/boot_entry_ctrl.sv
module boot_entry_ctrl #(
  parameter int PC_W       = 16,
  parameter int ALIGN_BITS = 4,
  parameter int CTRL_W     = 8,
  parameter int OVR_BIT    = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PC_W-1:0]             pc,
  input  logic                        ctrlWrEn,
  input  logic [CTRL_W-1:0]           ctrlWrData,
  input  logic                        romRestart,
  input  logic                        bootActive,
  output boot_entry_pkg::ctrlStrobes_t strobes
);

  logic keepRun;
  logic initDone;
  logic pcAligned;

  // Alignment detector: a zero-width window means every PC is a sample point.
  generate
    if (ALIGN_BITS == 0) begin : g_noAlign
      assign pcAligned = 1'b1;
    end else begin : g_align
      localparam int AW = ALIGN_BITS;
      assign pcAligned = (pc[AW-1:0] == '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepRun  <= 1'b0;
      initDone <= 1'b0;
    end else begin
      initDone <= 1'b1;
      if (ctrlWrEn) keepRun <= ctrlWrData[OVR_BIT];
    end
  end

  always_comb begin
    strobes.forceRun = keepRun;
    strobes.evalPins = 1'b0;
    if (!keepRun) begin
      if (!initDone)       strobes.evalPins = 1'b1;
      else if (bootActive) strobes.evalPins = romRestart;
      else                 strobes.evalPins = pcAligned;
    end
  end

endmodule

// File: rtl/boot_entry_dp.sv
module boot_entry_dp
  import boot_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modePins,
  input  ctrlStrobes_t      strobes,
  output logic              bootActive,
  output logic [MODE_W-1:0] bootSrc,
  output logic              fetchInhibit,
  output logic              secureErase
);

  logic activeQ, inhibitQ, eraseQ;
  logic [MODE_W-1:0] srcQ;
  logic wantBoot;

  assign wantBoot = |modePins;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      inhibitQ <= 1'b0;
      eraseQ   <= 1'b0;
      srcQ     <= '0;
    end else if (strobes.forceRun) begin
      activeQ  <= 1'b0;
      inhibitQ <= 1'b0;
      eraseQ   <= 1'b0;
      srcQ     <= '0;
    end else if (strobes.evalPins) begin
      activeQ  <= wantBoot;
      inhibitQ <= wantBoot;
      eraseQ   <= wantBoot && !activeQ;
      srcQ     <= modePins;
    end else begin
      eraseQ   <= 1'b0;
    end
  end

  assign bootActive   = activeQ;
  assign bootSrc      = srcQ;
  assign fetchInhibit = inhibitQ;
  assign secureErase  = eraseQ;

endmodule

// File: rtl/boot_entry_top.sv
module boot_entry_top
  import boot_entry_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int ALIGN_BITS = 4,
  parameter int CTRL_W     = 8,
  parameter int OVR_BIT    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modePins,
  input  logic [PC_W-1:0]   pc,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              romRestart,
  output logic              bootActive,
  output logic [1:0]        bootSrc,
  output logic              fetchInhibit,
  output logic              secureErase
);

  ctrlStrobes_t strobes;

  boot_entry_ctrl #(
    .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .CTRL_W(CTRL_W), .OVR_BIT(OVR_BIT)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pc         (pc),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .romRestart (romRestart),
    .bootActive (bootActive),
    .strobes    (strobes)
  );

  boot_entry_dp i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .modePins     (modePins),
    .strobes      (strobes),
    .bootActive   (bootActive),
    .bootSrc      (bootSrc),
    .fetchInhibit (fetchInhibit),
    .secureErase  (secureErase)
  );

endmodule

// File: rtl/boot_entry_checker.sv
module boot_entry_checker #(
  parameter int CTRL_W  = 8,
  parameter int OVR_BIT = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modePins,
  input logic              ctrlWrEn,
  input logic [CTRL_W-1:0] ctrlWrData,
  input logic              bootActive,
  input logic              fetchInhibit,
  input logic              secureErase
);

  AST_ERASE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    secureErase |-> (bootActive && !$past(bootActive))); // R4

  AST_RISE_GIVES_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bootActive) |-> secureErase); // R4

  AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    secureErase |=> !secureErase); // R4

  AST_ENTRY_NEEDS_STRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bootActive) |-> ($past(modePins) != 2'b00)); // R2

  AST_OVERRIDE_EXITS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[OVR_BIT]) |-> ##2 !bootActive); // R6

  AST_INHIBIT_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchInhibit) |-> $rose(bootActive)); // R3

endmodule

bind boot_entry_top boot_entry_checker #(.CTRL_W(CTRL_W), .OVR_BIT(OVR_BIT)) i_checker (
  .clk          (clk),
  .rstN         (rstN),
  .modePins     (modePins),
  .ctrlWrEn     (ctrlWrEn),
  .ctrlWrData   (ctrlWrData),
  .bootActive   (bootActive),
  .fetchInhibit (fetchInhibit),
  .secureErase  (secureErase)
);

// File: tb/test_boot_entry_top.sv
module test_boot_entry_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  modePins;
  logic [15:0] pc;
  logic        ctrlWrEn;
  logic [7:0]  ctrlWrData;
  logic        romRestart;
  logic        bootActive;
  logic [1:0]  bootSrc;
  logic        fetchInhibit;
  logic        secureErase;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  boot_entry_top i_boot_entry_top (
    .clk(clk), .rstN(rstN), .modePins(modePins), .pc(pc),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .romRestart(romRestart),
    .bootActive(bootActive), .bootSrc(bootSrc),
    .fetchInhibit(fetchInhibit), .secureErase(secureErase)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chkAll(input string req, input int act, input int src, input int ers);
    chk({req, " bootActive"},   int'(bootActive),   act);
    chk({req, " bootSrc"},      int'(bootSrc),      src);
    chk({req, " fetchInhibit"}, int'(fetchInhibit), act);
    chk({req, " secureErase"},  int'(secureErase),  ers);
  endtask

  // Reset, then release with strap p and an unaligned PC.
  task automatic bootWith(input int p);
    rstN = 1'b0; modePins = p[1:0]; pc = 16'h0101;
    ctrlWrEn = 1'b0; ctrlWrData = 8'h00; romRestart = 1'b0;
    step(); step();
    chkAll("R1 reset", 0, 0, 0);
    rstN = 1'b1;
    step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R2, R3, R4, R9: strap sweep at reset release
    for (int p = 0; p < 4; p++) begin
      bootWith(p);
      chkAll("R2 first sample", (p != 0) ? 1 : 0, p, (p != 0) ? 1 : 0);
      modePins = 2'(3 - p);
      step();
      chkAll("R9 strap ignored between samples", (p != 0) ? 1 : 0, p, 0);
    end

    // R5: restart resamples the strap while booting
    bootWith(1);
    for (int q = 3; q >= 1; q--) begin
      modePins = q[1:0]; romRestart = 1'b1;
      step();
      romRestart = 1'b0;
      chkAll("R5 restart resample", 1, q, 0);
    end
    modePins = 2'b00; romRestart = 1'b1;
    step();
    romRestart = 1'b0;
    chkAll("R5 restart to normal", 0, 0, 0);

    // R7: aligned-PC sampling sweep over all low nibbles
    for (int low = 0; low < 16; low++) begin
      modePins = 2'b10; pc = 16'hA5C0 | 16'(low);
      step();
      chkAll("R7 pc nibble", (low == 0) ? 1 : 0, (low == 0) ? 2 : 0, (low == 0) ? 1 : 0);
      if (low == 0) begin
        pc = 16'h0007; modePins = 2'b00; romRestart = 1'b1;
        step();
        romRestart = 1'b0;
        chkAll("R5 leave after aligned entry", 0, 0, 0);
      end
    end

    // R6: override write exits boot after two edges and freezes sampling
    bootWith(3);
    ctrlWrEn = 1'b1; ctrlWrData = 8'h80;
    step();
    ctrlWrEn = 1'b0; ctrlWrData = 8'h00;
    chkAll("R6 one edge after write", 1, 3, 0);
    step();
    chkAll("R6 two edges after write", 0, 0, 0);
    modePins = 2'b01; pc = 16'h1230; romRestart = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chkAll("R6 strap/pc/restart ignored", 0, 0, 0);
    end
    romRestart = 1'b0;

    // R8: write strobe gates the override; clearing it re-arms sampling
    ctrlWrData = 8'h00;
    step();
    chkAll("R8 data without strobe", 0, 0, 0);
    ctrlWrEn = 1'b1; ctrlWrData = 8'h7F;
    step();
    ctrlWrEn = 1'b0; ctrlWrData = 8'h00;
    chkAll("R8 cleared, not yet sampled", 0, 0, 0);
    step();
    chkAll("R8 R7 entry after clear", 1, 1, 1);
    step();
    chkAll("R4 no repeat erase", 1, 1, 0);

    // R7: normal strap keeps normal fetch at aligned PCs
    bootWith(0);
    pc = 16'h0000;
    for (int i = 0; i < 3; i++) begin
      step();
      chkAll("R7 strap 00 at aligned pc", 0, 0, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule